// File: doc/BRIEF.md
# Cycle Counter with Compare-Match Interrupt

This block keeps a free-running cycle counter that advances by one on every clock, and a 32-bit compare value that shares a single register address with it. A read request at that address returns the counter; a write request at the same address loads the compare value, which can never be read back. Whenever the lowest 32 bits of the counter are exactly equal to the compare value, a sticky pending flag is raised. Software then acknowledges the flag with a one-cycle pulse.

The interrupt output is the pending flag gated by an enable input, which is registered inside the block. Masking only hides the output: matches keep raising the pending flag. The match is a strict equality. A compare value written behind the counter therefore fires only after the low 32 bits wrap round to it. The counter is 32 or 64 bits wide. With 64 bits, only the low half takes part in the match.

The register port is a single-cycle request port. Each read request produces one result, flagged with `rd_vld` one cycle later. The port has no back-pressure: a result is valid for exactly one cycle and the consumer must take it then. Writes return nothing.

Top module: `cycle_match_timer`

## Requirements
- R1: The counter starts from parameter `CNT_RST` (default 0) when reset is released and increases by exactly one on every clock cycle after that.
- R2: Parameter `CNT_W` is 32 or 64. With 64, the counter carries from bit 31 into bit 32, so a full 64-bit value is returned on reads.
- R3: A read request (`acc_en`=1, `acc_we`=0) makes `rd_vld` 1 in the next cycle, with `rd_data` holding the counter value from the request cycle. In every other cycle `rd_vld` is 0, and the compare value never appears on `rd_data`.
- R4: A write request (`acc_en`=1, `acc_we`=1) loads `acc_wdata[31:0]` into the compare register. The new value takes effect from the next cycle on.
- R5: In a cycle where counter bits [31:0] equal the compare value, the pending flag is set at the end of that cycle. With the enable set, `irq` is 1 from the next cycle on. Counter bits above 31 are ignored.
- R6: A compare value written behind the counter causes no interrupt until counter bits [31:0] wrap round and reach it.
- R7: The pending flag stays set until `irq_ack` is 1 in a cycle without a match, and it clears at the end of that cycle. A match and an acknowledge in the same cycle leave the flag set.
- R8: `irq` is the pending flag ANDed with `irq_en` as registered at the previous clock edge. While `irq_en` is 0, matches still set the pending flag, and the flag shows on `irq` one cycle after `irq_en` returns to 1.
- R9: Reset (`rst_n`=0) clears the compare register, the pending flag, the registered enable and `rd_vld`, and holds `irq` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Register access request at the shared address |
| acc_we | input | 1 | 1 = write the compare value, 0 = read the counter |
| acc_wdata | input | 32 | Compare value to load |
| rd_vld | output | 1 | Read result valid, for one cycle only |
| rd_data | output | CNT_W | Counter value captured in the request cycle |
| irq_en | input | 1 | Interrupt output enable (mask) |
| irq_ack | input | 1 | Acknowledge pulse that clears the pending flag |
| irq | output | 1 | Masked interrupt |

## Verification
The bench builds the block with `CNT_W`=64 and `CNT_RST`=64'h1_FFFF_FF00. Counter bits [31:0] therefore wrap about 256 cycles after reset, and a carry passes into bit 32. This brings R6 and the 64-bit half of R2 within reach of a short run. It checks that a compare value of 5 matches only after the wrap, while the upper half reads 2. It also shows that a compare value behind the counter stays silent, that an acknowledge in the same cycle as a match leaves the flag set, and that a match taken while masked appears once the enable returns.

// File: rtl/ctm_pkg.sv
package ctm_pkg;
  localparam int unsigned CMP_W = 32;
  typedef logic [CMP_W-1:0] cmp_t;
endpackage

// File: rtl/ctm_counter.sv
module ctm_counter #(
  parameter int unsigned        CNT_W   = 32,
  parameter logic [CNT_W-1:0]   CNT_RST = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int unsigned HALF = 32;

  generate
    if (CNT_W == 64) begin : g_wide
      // two 32-bit halves: the upper half steps when the lower is all ones
      logic [HALF-1:0] lo_q;
      logic [HALF-1:0] hi_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lo_q <= CNT_RST[HALF-1:0];
          hi_q <= CNT_RST[CNT_W-1:HALF];
        end else begin
          lo_q <= lo_q + 1'b1;
          if (&lo_q) hi_q <= hi_q + 1'b1;
        end
      end
      assign cnt_o = {hi_q, lo_q};
    end else begin : g_narrow
      logic [CNT_W-1:0] c_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= CNT_RST;
        else        c_q <= c_q + 1'b1;
      end
      assign cnt_o = c_q;
    end
  endgenerate
endmodule

// File: rtl/ctm_compare.sv
module ctm_compare
  import ctm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ld_i,
  input  cmp_t ld_val_i,
  input  cmp_t cnt_lo_i,
  output cmp_t cmp_o,
  output logic hit_o
);
  cmp_t cmp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cmp_q <= '0;
    else if (ld_i) cmp_q <= ld_val_i;
  end

  // strict equality on the low word only
  assign hit_o = (cnt_lo_i == cmp_q);
  assign cmp_o = cmp_q;
endmodule

// File: rtl/ctm_pending.sv
module ctm_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  logic ack_i,
  input  logic en_i,
  output logic pend_o,
  output logic en_q_o,
  output logic irq_o
);
  logic pend_q;
  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      en_q <= en_i;
      // a match outranks an acknowledge in the same cycle
      if (hit_i)      pend_q <= 1'b1;
      else if (ack_i) pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign en_q_o = en_q;
  assign irq_o  = pend_q & en_q;
endmodule

// File: rtl/cycle_match_timer.sv
module cycle_match_timer
  import ctm_pkg::*;
#(
  parameter int unsigned      CNT_W   = 32,
  parameter logic [CNT_W-1:0] CNT_RST = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic             acc_we,
  input  logic [31:0]      acc_wdata,
  output logic             rd_vld,
  output logic [CNT_W-1:0] rd_data,
  input  logic             irq_en,
  input  logic             irq_ack,
  output logic             irq
);
  logic [CNT_W-1:0] cnt_w;
  cmp_t             cmp_w;
  logic             hit_w;
  logic             pend_w;
  logic             en_w;
  logic             rd_req;
  logic             wr_req;
  logic             rd_vld_q;
  logic [CNT_W-1:0] rd_data_q;

  assign rd_req = acc_en & ~acc_we;
  assign wr_req = acc_en &  acc_we;

  ctm_counter #(.CNT_W(CNT_W), .CNT_RST(CNT_RST)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt_o (cnt_w)
  );

  ctm_compare u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_i     (wr_req),
    .ld_val_i (acc_wdata),
    .cnt_lo_i (cnt_w[CMP_W-1:0]),
    .cmp_o    (cmp_w),
    .hit_o    (hit_w)
  );

  ctm_pending u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit_i  (hit_w),
    .ack_i  (irq_ack),
    .en_i   (irq_en),
    .pend_o (pend_w),
    .en_q_o (en_w),
    .irq_o  (irq)
  );

  // read return: one result per request, one cycle later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld_q  <= 1'b0;
      rd_data_q <= '0;
    end else begin
      rd_vld_q <= rd_req;
      if (rd_req) rd_data_q <= cnt_w;
    end
  end

  assign rd_vld  = rd_vld_q;
  assign rd_data = rd_data_q;
endmodule

// File: rtl/ctm_checker.sv
module ctm_checker #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_en,
  input logic             acc_we,
  input logic [31:0]      acc_wdata,
  input logic             irq_en,
  input logic             irq_ack,
  input logic             irq,
  input logic             rd_vld,
  input logic [CNT_W-1:0] rd_data,
  input logic [CNT_W-1:0] cnt,
  input logic [31:0]      cmp,
  input logic             hit,
  input logic             pend
);
  localparam logic [CNT_W-1:0] ONE = 1;

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (cnt == $past(cnt) + ONE));

  assert_read_return_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_we) |=> (rd_vld && rd_data == $past(cnt)));

  assert_no_stray_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && !acc_we) |=> !rd_vld);

  assert_cmp_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_we) |=> (cmp == $past(acc_wdata)));

  assert_match_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> pend);

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !irq_ack) |=> pend);

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !hit) |=> !pend);

  assert_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> !irq);
endmodule

bind cycle_match_timer ctm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_en    (acc_en),
  .acc_we    (acc_we),
  .acc_wdata (acc_wdata),
  .irq_en    (irq_en),
  .irq_ack   (irq_ack),
  .irq       (irq),
  .rd_vld    (rd_vld),
  .rd_data   (rd_data),
  .cnt       (cnt_w),
  .cmp       (cmp_w),
  .hit       (hit_w),
  .pend      (pend_w)
);

// File: tb/sim_cycle_match_timer.sv
`timescale 1ns/1ps
module sim_cycle_match_timer;
  localparam int unsigned CW   = 64;
  localparam logic [CW-1:0] RSTV = 64'h0000_0001_FFFF_FF00;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_en = 1'b0;
  logic          acc_we = 1'b0;
  logic [31:0]   acc_wdata = '0;
  logic          irq_en = 1'b0;
  logic          irq_ack = 1'b0;
  logic          rd_vld;
  logic [CW-1:0] rd_data;
  logic          irq;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  cycle_match_timer #(.CNT_W(CW), .CNT_RST(RSTV)) u0 (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
    .acc_wdata(acc_wdata), .rd_vld(rd_vld), .rd_data(rd_data),
    .irq_en(irq_en), .irq_ack(irq_ack), .irq(irq)
  );

  // requirement model, advanced at each rising edge
  logic [CW-1:0] m_cnt;
  logic [31:0]   m_cmp;
  logic          m_pend;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= RSTV; m_cmp <= '0; m_pend <= 1'b0;
    end else begin
      m_cnt <= m_cnt + 64'd1;
      if (acc_en && acc_we) m_cmp <= acc_wdata;
      if (m_cnt[31:0] == m_cmp) m_pend <= 1'b1;
      else if (irq_ack)         m_pend <= 1'b0;
    end
  end

  logic [CW-1:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input logic [CW-1:0] act,
                     input logic [CW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // driver: read request, expected value pushed to the scoreboard
  task automatic do_read();
    acc_en = 1'b1; acc_we = 1'b0;
    exp_q.push_back(m_cnt);
    step();
    acc_en = 1'b0;
  endtask

  task automatic do_write(input logic [31:0] v);
    acc_en = 1'b1; acc_we = 1'b1; acc_wdata = v;
    step();
    acc_en = 1'b0; acc_we = 1'b0;
  endtask

  task automatic wait_low(input logic [31:0] v);
    while (m_cnt[31:0] != v) step();
  endtask

  // monitor: pops expected read results as the design returns them
  always @(negedge clk) begin
    if (rst_n && rd_vld) begin
      if (exp_q.size() == 0) chk(1'b0, "R3 unexpected rd_vld", 64'd1, 64'd0);
      else begin
        logic [CW-1:0] e;
        e = exp_q.pop_front();
        chk(rd_data == e, "R1 R3 read value", rd_data, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] t;
    repeat (3) step();
    // R9 reset state
    chk(irq == 1'b0, "R9 irq in reset", {63'd0, irq}, 64'd0);
    chk(rd_vld == 1'b0, "R9 rd_vld in reset", {63'd0, rd_vld}, 64'd0);
    rst_n = 1'b1;
    // R1 counter reads a few cycles apart
    do_read();
    repeat (4) step();
    do_read();
    chk(rd_vld == 1'b1, "R3 valid after read", {63'd0, rd_vld}, 64'd1);
    irq_en = 1'b1;

    // R6 compare value behind the counter stays silent
    do_write(m_cnt[31:0] - 32'd3);
    chk(rd_vld == 1'b0, "R4 write gives no read result", {63'd0, rd_vld}, 64'd0);
    repeat (40) step();
    chk(irq == 1'b0, "R6 behind value no irq", {63'd0, irq}, 64'd0);

    // R5 exact match timing
    t = m_cnt[31:0] + 32'd8;
    do_write(t);
    wait_low(t);
    chk(irq == 1'b0, "R5 irq not before match edge", {63'd0, irq}, 64'd0);
    step();
    chk(irq == 1'b1, "R5 irq after match", {63'd0, irq}, 64'd1);
    do_read();
    repeat (6) step();
    chk(irq == 1'b1, "R7 sticky pending", {63'd0, irq}, 64'd1);
    irq_ack = 1'b1; step(); irq_ack = 1'b0;
    chk(irq == 1'b0, "R7 ack clears", {63'd0, irq}, 64'd0);

    // R7 ack in the match cycle leaves the flag set
    t = m_cnt[31:0] + 32'd6;
    do_write(t);
    wait_low(t);
    irq_ack = 1'b1; step(); irq_ack = 1'b0;
    chk(irq == 1'b1, "R7 match beats ack", {63'd0, irq}, 64'd1);
    irq_ack = 1'b1; step(); irq_ack = 1'b0;
    chk(irq == 1'b0, "R7 second ack clears", {63'd0, irq}, 64'd0);

    // R8 masked match is kept pending
    irq_en = 1'b0;
    t = m_cnt[31:0] + 32'd6;
    do_write(t);
    wait_low(t + 32'd2);
    chk(irq == 1'b0, "R8 masked irq low", {63'd0, irq}, 64'd0);
    irq_en = 1'b1;
    chk(irq == 1'b0, "R8 enable registered", {63'd0, irq}, 64'd0);
    step();
    chk(irq == 1'b1, "R8 pending shown after unmask", {63'd0, irq}, 64'd1);
    irq_ack = 1'b1; step(); irq_ack = 1'b0;

    // R6 and R2: small compare value matches after the low word wraps
    do_write(32'd5);
    chk(irq == 1'b0, "R6 no irq before wrap", {63'd0, irq}, 64'd0);
    wait_low(32'd5);
    chk(irq == 1'b0, "R5 irq low in match cycle", {63'd0, irq}, 64'd0);
    step();
    chk(irq == 1'b1, "R6 irq after wrap", {63'd0, irq}, 64'd1);
    do_read();
    chk(rd_data[63:32] == 32'd2, "R2 carry into upper half",
        {32'd0, rd_data[63:32]}, 64'd2);
    step();
    chk(exp_q.size() == 0, "R3 all reads returned", 64'(exp_q.size()), 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule